// File: doc/BRIEF.md
# Coprocessor Offload Issuer

This block sits in a processor decode stage and passes one instruction at a time to an external accelerator predecoder. The decode stage hands an instruction word to the block over a valid/ready input stream, together with a flag that says whether the core's own decoder recognises the word. The block keeps that word in a holding register and offers it on a request channel. It waits for the predecoder's ready. In the transfer cycle it samples the predecoder's combinational answer: an accept flag, three source-operand-use flags and a dual-writeback flag.

One cycle after the transfer, the block reports the outcome. It gives an offload-accepted pulse together with the operand and writeback flags when the accelerator claimed the word. It gives an illegal-instruction pulse when neither the accelerator nor the local decoder claims it. It gives neither pulse when only the local decoder claims it. The operand flags let the core wait only for the register reads that the accelerator will actually use. A flush drops a pending request that has not yet met ready.

Back-pressure rules. On the input stream, a word is taken in any cycle where `in_valid_i` and `in_ready_o` are both high. On the request channel, `req_valid_o` is driven from a register and never from `req_ready_i`. The predecoder may hold ready high while nothing is offered. It may also withdraw ready at any cycle before the transfer, and the request then stays unchanged until a transfer or a flush.

Top module: `offload_issuer`

## Requirements
- R1: `req_valid_o` rises only in the cycle after an input transfer (`in_valid_i` and `in_ready_o` both high). It is produced from a register, so `req_ready_i` never affects it combinationally.
- R2: While `req_valid_o` is high and no transfer or flush takes place, `req_instr_o` and `req_valid_o` keep their values in the next cycle.
- R3: `req_ready_i` high while `req_valid_o` is low produces no pulse and no state change. `req_ready_i` low while a request is pending leaves the request pending.
- R4: A transfer (`req_valid_o` and `req_ready_i` both high) with `rsp_accept_i` high gives `offload_ok_o` high for exactly the next cycle. In that same cycle, `use_ops_o` equals the sampled `rsp_use_i` (bit 0 first source, bit 1 second, bit 2 third) and `dual_wb_o` equals the sampled `rsp_dual_wb_i`.
- R5: A transfer with `rsp_accept_i` low, where the captured local-decode flag was low, gives `illegal_o` high for exactly the next cycle.
- R6: A transfer with `rsp_accept_i` low, where the captured local-decode flag was high, gives neither pulse. `use_ops_o` and `dual_wb_o` are zero in every cycle where `offload_ok_o` is low.
- R7: `flush_i` while a request is pending and `req_ready_i` is low clears `req_valid_o` in the next cycle, and no pulse follows. `flush_i` in a transfer cycle does not cancel that transfer.
- R8: `in_ready_o` equals (no request pending, or a transfer this cycle) and not `flush_i`. This allows a new word to be offered in the cycle right after a transfer.
- R9: `offload_ok_o` and `illegal_o` are never high together, and each transfer produces at most one single-cycle pulse.
- R10: During reset, `req_valid_o`, `offload_ok_o`, `illegal_o`, `use_ops_o` and `dual_wb_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decode stage offers an instruction |
| in_instr_i | input | INSTR_W | Instruction word offered |
| in_local_ok_i | input | 1 | Local decoder recognises the offered word |
| in_ready_o | output | 1 | Block takes the offered word this cycle |
| flush_i | input | 1 | Drop a pending request that has not met ready |
| req_valid_o | output | 1 | Request channel valid |
| req_instr_o | output | INSTR_W | Request channel instruction word |
| req_ready_i | input | 1 | Request channel ready from the predecoder |
| rsp_accept_i | input | 1 | Predecoder claims the word (valid with ready) |
| rsp_use_i | input | 3 | Source operands the accelerator reads (valid with ready) |
| rsp_dual_wb_i | input | 1 | Accelerator writes two destination registers (valid with ready) |
| offload_ok_o | output | 1 | One-cycle pulse: offload committed |
| use_ops_o | output | 3 | Operand-use flags, valid with `offload_ok_o` |
| dual_wb_o | output | 1 | Dual-writeback flag, valid with `offload_ok_o` |
| illegal_o | output | 1 | One-cycle pulse: nobody claims the word |

## Verification
The hardest cases to bring about are the ones at the edge of the transfer cycle. One is a flush in the very cycle ready arrives. The other is a new word offered in the same cycle a transfer completes. Both need ready, flush and the input valid to be lined up on one exact edge. Directed sequences place each of them deliberately. A long random phase then toggles ready, flush and the input valid independently of each other, so that withdrawn ready, default-high ready and flush collisions occur many times over. A behavioural model checks every output on every cycle.

// File: rtl/offload_pkg.sv
package offload_pkg;
  localparam int unsigned NUM_OPS = 3;

  typedef struct packed {
    logic               accept;
    logic [NUM_OPS-1:0] use_ops;
    logic               dual_wb;
  } rsp_t;
endpackage

// File: rtl/offload_req_hold.sv
module offload_req_hold #(
  parameter int unsigned INSTR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               in_valid_i,
  input  logic [INSTR_W-1:0] in_instr_i,
  input  logic               in_local_ok_i,
  output logic               in_ready_o,
  output logic               req_valid_o,
  output logic [INSTR_W-1:0] req_instr_o,
  input  logic               req_ready_i,
  output logic               held_local_o,
  output logic               fire_o
);
  logic               pend_q;
  logic [INSTR_W-1:0] instr_q;
  logic               local_q;
  logic               take;

  assign fire_o       = pend_q & req_ready_i;
  assign in_ready_o   = (~pend_q | req_ready_i) & ~flush_i;
  assign take         = in_valid_i & in_ready_o;
  assign req_valid_o  = pend_q;
  assign req_instr_o  = instr_q;
  assign held_local_o = local_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      instr_q <= '0;
      local_q <= 1'b0;
    end else if (take) begin
      pend_q  <= 1'b1;
      instr_q <= in_instr_i;
      local_q <= in_local_ok_i;
    end else if (fire_o || flush_i) begin
      pend_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/offload_rsp_classify.sv
module offload_rsp_classify
  import offload_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               held_local_i,
  input  rsp_t               rsp_i,
  output logic               ok_o,
  output logic               illegal_o,
  output logic [NUM_OPS-1:0] use_ops_o,
  output logic               dual_wb_o
);
  logic claim;
  assign claim = fire_i & rsp_i.accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_o      <= 1'b0;
      illegal_o <= 1'b0;
      dual_wb_o <= 1'b0;
    end else begin
      ok_o      <= claim;
      illegal_o <= fire_i & ~rsp_i.accept & ~held_local_i;
      dual_wb_o <= claim & rsp_i.dual_wb;
    end
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) use_ops_o[g] <= 1'b0;
      else         use_ops_o[g] <= claim & rsp_i.use_ops[g];
    end
  end
endmodule

// File: rtl/offload_issuer.sv
module offload_issuer
  import offload_pkg::*;
#(
  parameter int unsigned INSTR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [INSTR_W-1:0] in_instr_i,
  input  logic               in_local_ok_i,
  output logic               in_ready_o,
  input  logic               flush_i,
  output logic               req_valid_o,
  output logic [INSTR_W-1:0] req_instr_o,
  input  logic               req_ready_i,
  input  logic               rsp_accept_i,
  input  logic [2:0]         rsp_use_i,
  input  logic               rsp_dual_wb_i,
  output logic               offload_ok_o,
  output logic [2:0]         use_ops_o,
  output logic               dual_wb_o,
  output logic               illegal_o
);
  logic fire;
  logic held_local;
  rsp_t rsp;

  assign rsp.accept  = rsp_accept_i;
  assign rsp.use_ops = rsp_use_i;
  assign rsp.dual_wb = rsp_dual_wb_i;

  offload_req_hold #(.INSTR_W(INSTR_W)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .in_valid_i   (in_valid_i),
    .in_instr_i   (in_instr_i),
    .in_local_ok_i(in_local_ok_i),
    .in_ready_o   (in_ready_o),
    .req_valid_o  (req_valid_o),
    .req_instr_o  (req_instr_o),
    .req_ready_i  (req_ready_i),
    .held_local_o (held_local),
    .fire_o       (fire)
  );

  offload_rsp_classify u_cls (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .held_local_i(held_local),
    .rsp_i       (rsp),
    .ok_o        (offload_ok_o),
    .illegal_o   (illegal_o),
    .use_ops_o   (use_ops_o),
    .dual_wb_o   (dual_wb_o)
  );
endmodule

// File: rtl/offload_issuer_chk.sv
module offload_issuer_chk #(
  parameter int unsigned INSTR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               in_ready_o,
  input logic               flush_i,
  input logic               req_valid_o,
  input logic [INSTR_W-1:0] req_instr_o,
  input logic               req_ready_i,
  input logic               rsp_accept_i,
  input logic               offload_ok_o,
  input logic [2:0]         use_ops_o,
  input logic               dual_wb_o,
  input logic               illegal_o
);
  AST_VALID_FROM_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(in_valid_i && in_ready_o)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && !flush_i) |=> (req_valid_o && $stable(req_instr_o))); // R2
  AST_ACCEPT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i && rsp_accept_i) |=> offload_ok_o); // R4
  AST_REJECT_NO_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i && !rsp_accept_i) |=> !offload_ok_o); // R6
  AST_FLAGS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !offload_ok_o |-> (use_ops_o == 3'b000 && !dual_wb_o)); // R6
  AST_FLUSH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && flush_i) |=> !req_valid_o); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(offload_ok_o && illegal_o)); // R9
  AST_PULSE_NEEDS_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offload_ok_o || illegal_o) |-> $past(req_valid_o && req_ready_i)); // R9
endmodule

bind offload_issuer offload_issuer_chk #(.INSTR_W(INSTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .flush_i     (flush_i),
  .req_valid_o (req_valid_o),
  .req_instr_o (req_instr_o),
  .req_ready_i (req_ready_i),
  .rsp_accept_i(rsp_accept_i),
  .offload_ok_o(offload_ok_o),
  .use_ops_o   (use_ops_o),
  .dual_wb_o   (dual_wb_o),
  .illegal_o   (illegal_o)
);

// File: tb/offload_issuer_bench.sv
module offload_issuer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iv = 1'b0, lok = 1'b0, fl = 1'b0, rdy = 1'b0, acc = 1'b0, dw = 1'b0;
  logic [31:0] ins = '0;
  logic [2:0]  usev = '0;
  logic        in_rdy, rv, ok, ill, dwo;
  logic [31:0] rins;
  logic [2:0]  uso;

  int vecs = 0, errs = 0;
  bit done = 0;

  // reference model state
  bit          m_pend = 0, m_loc = 0, m_ok = 0, m_ill = 0, m_dw = 0;
  logic [31:0] m_ins = '0;
  logic [2:0]  m_use = '0;

  always #10 clk = ~clk;

  offload_issuer u_offload_issuer (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(iv), .in_instr_i(ins), .in_local_ok_i(lok), .in_ready_o(in_rdy),
    .flush_i(fl), .req_valid_o(rv), .req_instr_o(rins), .req_ready_i(rdy),
    .rsp_accept_i(acc), .rsp_use_i(usev), .rsp_dual_wb_i(dw),
    .offload_ok_o(ok), .use_ops_o(uso), .dual_wb_o(dwo), .illegal_o(ill)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] w, input bit lo, input bit f,
                      input bit r, input bit a, input logic [2:0] u, input bit d, input string tag);
    bit exp_rdy, fire, take;
    @(negedge clk);
    iv = v; ins = w; lok = lo; fl = f; rdy = r; acc = a; usev = u; dw = d;
    #1;
    fire    = m_pend && r;
    exp_rdy = (!m_pend || r) && !f;
    take    = v && exp_rdy;
    chk({tag, "/R1"}, "req_valid", rv, m_pend);
    if (m_pend) chk({tag, "/R2"}, "req_instr", rins, m_ins);
    chk({tag, "/R8"}, "in_ready", in_rdy, exp_rdy);
    chk({tag, "/R4"}, "offload_ok", ok, m_ok);
    chk({tag, "/R5"}, "illegal", ill, m_ill);
    chk({tag, "/R6"}, "use_ops", uso, m_use);
    chk({tag, "/R4"}, "dual_wb", dwo, m_dw);
    @(posedge clk);
    m_ok  = fire && a;
    m_ill = fire && !a && !m_loc;
    m_use = (fire && a) ? u : 3'b000;
    m_dw  = fire && a && d;
    if (take) begin
      m_pend = 1; m_ins = w; m_loc = lo;
    end else if (fire || f) m_pend = 0;
  endtask

  task automatic idle(input string tag);
    step(0, 32'h0, 0, 0, 0, 0, 3'b000, 0, tag);
  endtask

  initial begin
    // R10: outputs low during reset
    repeat (2) @(negedge clk);
    chk("R10", "req_valid", rv, 0);
    chk("R10", "offload_ok", ok, 0);
    chk("R10", "illegal", ill, 0);
    chk("R10", "use_ops", uso, 0);
    chk("R10", "dual_wb", dwo, 0);
    rst_n = 1'b1;
    idle("R10");

    // R4: accepted offload with flags
    step(1, 32'h0000_A00B, 0, 0, 0, 0, 3'b000, 0, "R4");
    step(0, 32'h0, 0, 0, 1, 1, 3'b101, 1, "R4");
    idle("R4"); idle("R4");

    // R5: nobody claims
    step(1, 32'h1111_2222, 0, 0, 0, 0, 3'b000, 0, "R5");
    step(0, 32'h0, 0, 0, 1, 0, 3'b111, 1, "R5");
    idle("R5"); idle("R5");

    // R6: local decoder claims, accelerator declines
    step(1, 32'h3333_4444, 1, 0, 0, 0, 3'b000, 0, "R6");
    step(0, 32'h0, 0, 0, 1, 0, 3'b011, 1, "R6");
    idle("R6"); idle("R6");

    // R3: default-high ready while idle, then withdrawn ready
    step(0, 32'h0, 0, 0, 1, 1, 3'b111, 1, "R3");
    step(0, 32'h0, 0, 0, 1, 1, 3'b111, 1, "R3");
    step(1, 32'h5555_6666, 0, 0, 1, 0, 3'b000, 0, "R3");
    step(1, 32'hDEAD_BEEF, 0, 0, 0, 1, 3'b111, 1, "R3");
    step(1, 32'hFEED_F00D, 1, 0, 0, 1, 3'b111, 1, "R3");
    step(0, 32'h0, 0, 0, 1, 1, 3'b010, 0, "R3");
    idle("R3"); idle("R3");

    // R7: flush while waiting, then flush in a transfer cycle
    step(1, 32'h7777_0001, 0, 0, 0, 0, 3'b000, 0, "R7");
    step(1, 32'h7777_0002, 0, 1, 0, 1, 3'b111, 0, "R7");
    idle("R7"); idle("R7");
    step(1, 32'h7777_0003, 0, 0, 0, 0, 3'b000, 0, "R7");
    step(1, 32'h7777_0004, 0, 1, 1, 1, 3'b001, 1, "R7");
    idle("R7"); idle("R7");

    // R8: back-to-back words
    step(1, 32'h8888_0001, 0, 0, 0, 0, 3'b000, 0, "R8");
    step(1, 32'h8888_0002, 1, 0, 1, 1, 3'b100, 0, "R8");
    step(1, 32'h8888_0003, 0, 0, 1, 0, 3'b000, 0, "R8");
    step(0, 32'h0, 0, 0, 1, 1, 3'b110, 1, "R8");
    idle("R8"); idle("R8");

    // R9: random mix
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 1), $urandom, $urandom_range(0, 1),
           ($urandom_range(0, 9) == 0), $urandom_range(0, 1), $urandom_range(0, 1),
           3'($urandom_range(0, 7)), $urandom_range(0, 1), "R9");
    end
    idle("R9");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule